// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block holds one 64-bit message register for each CPU of a multiprocessor. Any CPU can drop a message into any other CPU's register, and the target CPU can later take it out. Only one message is kept per CPU and nothing is queued. A newer message replaces an older one that has not been read, so the most recent message is the one that counts.

Every CPU has a post port made of a valid bit, a target index and a data word. The source is given by the index of the port. Every CPU also has a fetch request that returns the stored word and empties the register in a single clock edge, a peek output that shows the stored word at all times, and a pending flag. The pending flags go to the shared interrupt request logic as the inter-processor interrupt source, one per CPU. Arbitration between interrupt sources, masking, command handling and acknowledgements are outside this block.

In the data word the command sits in the top byte, bits [63:56], and the parameter fills bits [55:0]. A word of all zeros means "empty", so a post of zero does nothing. The CPU count is a parameter.

Top module: `ipi_mailbox`

## Requirements
- R1: After a synchronous reset every slot holds zero, every pending flag is low, every fetch_valid is low and every fetch_data word is zero.
- R2: A post with a non-zero word to target t replaces the contents of slot t at the next clock edge, whether or not the old word was read. From then on peek_data for t shows the new word.
- R3: When fetch_req[t] is high at an edge, fetch_valid[t] is high in the following cycle and fetch_data for t holds the word slot t had before that edge. The slot is then zero unless a post lands in the same edge. When fetch_req[t] is low at an edge, fetch_valid[t] is low afterwards.
- R4: peek_data for each CPU always equals its slot contents and reading it changes nothing.
- R5: ipi_pending[t] is high exactly when slot t holds a non-zero word.
- R6: fetch_cmd for t equals bits [63:56] of the fetched word, and the parameter is bits [55:0] of that word.
- R7: When several sources post non-zero words to one target in the same cycle, the source with the lowest index wins and only its word is stored.
- R8: A post whose data is all zeros is ignored. It does not change the slot and it does not take part in the priority choice of R7.
- R9: When a post and a fetch hit the same slot in the same cycle, the fetch returns the old word and the slot ends up holding the posted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | N_CPU | Post request, one bit per source CPU |
| post_target | input | N_CPU*TGT_W | Target index per source, source s in bits [s*TGT_W +: TGT_W] |
| post_data | input | N_CPU*64 | Message word per source, source s in bits [s*64 +: 64] |
| fetch_req | input | N_CPU | Read-and-clear request per CPU |
| fetch_valid | output | N_CPU | Registered: a fetch completed at the last edge |
| fetch_data | output | N_CPU*64 | Registered fetched word per CPU (holds its value between fetches) |
| fetch_cmd | output | N_CPU*8 | Registered command byte of the fetched word per CPU |
| peek_data | output | N_CPU*64 | Current slot contents per CPU |
| ipi_pending | output | N_CPU | Slot non-zero, one bit per CPU |

## Verification
A four-CPU instance is swept over every pairing of source and target, and each post is followed by every one of the sixteen fetch-request patterns. This separates a message that reaches the wrong slot from one that is cleared by another CPU's fetch. Directed cycles cover an overwrite before any read, a post of zero, all four sources posting to one target with and without a zero word from the lowest source, and a post that coincides with a fetch of the same slot. These expose a wrong priority order, a zero word that wins arbitration, and a fetch that returns the new word instead of the old one. A long pseudo-random run then mixes concurrent posts, zero words and fetches, and a reference model in the bench predicts every output of every CPU in every cycle.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  // Message word layout: command byte at the top, parameter below it.
  localparam int unsigned MSG_W   = 64;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned PARAM_W = MSG_W - CMD_W;

  typedef logic [MSG_W-1:0] ipi_word_t;
  typedef logic [CMD_W-1:0] ipi_cmd_t;

  function automatic ipi_cmd_t word_cmd(input ipi_word_t w);
    return w[MSG_W-1 -: CMD_W];
  endfunction

  function automatic logic [PARAM_W-1:0] word_param(input ipi_word_t w);
    return w[PARAM_W-1:0];
  endfunction
endpackage

// File: rtl/ipi_post_arbiter.sv
// Picks, for one target slot, the posting source with the lowest index
// that carries a non-zero word.
module ipi_post_arbiter #(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned TGT_W  = 2,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TARGET = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CPU-1:0]        post_valid,
  input  logic [N_CPU*TGT_W-1:0]  post_target,
  input  logic [N_CPU*DATA_W-1:0] post_data,
  output logic [N_CPU-1:0]        grant,
  output logic                    win_we,
  output logic [DATA_W-1:0]       win_data
);
  localparam logic [TGT_W-1:0] MY_IDX = TGT_W'(TARGET);

  logic [N_CPU-1:0] cand;

  genvar s;
  generate
    for (s = 0; s < N_CPU; s++) begin : g_cand
      assign cand[s] = post_valid[s]
                     && (post_target[s*TGT_W +: TGT_W] == MY_IDX)
                     && (post_data[s*DATA_W +: DATA_W] != '0);
    end
  endgenerate

  always_comb begin
    grant    = '0;
    win_we   = 1'b0;
    win_data = '0;
    for (int i = N_CPU - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        win_we   = 1'b1;
        win_data = post_data[i*DATA_W +: DATA_W];
      end
    end
  end

  // R7: at most one source is chosen per target per cycle
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R8: a chosen write never carries the empty word
  assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
    win_we |-> (win_data != '0));

  // R7: a granted source really posted to this target
  assert_grant_is_poster_R7: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((grant & post_valid) == grant));
endmodule

// File: rtl/ipi_slot.sv
// One CPU's message register with read-and-clear fetch and pending flag.
module ipi_slot #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch_req,
  output logic [DATA_W-1:0] slot_q,
  output logic              pending_q,
  output logic              fetch_valid_q,
  output logic [DATA_W-1:0] fetch_data_q,
  output logic [CMD_W-1:0]  fetch_cmd_q
);
  logic [DATA_W-1:0] slot_d;

  // A post wins over the clear done by a fetch in the same edge.
  always_comb begin
    if (wr_en)          slot_d = wr_data;
    else if (fetch_req) slot_d = '0;
    else                slot_d = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q        <= '0;
      pending_q     <= 1'b0;
      fetch_valid_q <= 1'b0;
      fetch_data_q  <= '0;
      fetch_cmd_q   <= '0;
    end else begin
      slot_q        <= slot_d;
      pending_q     <= (slot_d != '0);
      fetch_valid_q <= fetch_req;
      if (fetch_req) begin
        fetch_data_q <= slot_q;
        fetch_cmd_q  <= slot_q[DATA_W-1 -: CMD_W];
      end
    end
  end

  // R5: the pending flop agrees with the slot contents
  assert_pending_match_R5: assert property (@(posedge clk) disable iff (rst)
    pending_q == (slot_q != '0));

  // R3: a fetch returns the word held before the edge
  assert_fetch_old_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> (fetch_valid_q && fetch_data_q == $past(slot_q)));

  // R3: a fetch without a post empties the slot
  assert_fetch_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !wr_en) |=> (slot_q == '0));

  // R2 / R9: a write always lands, even alongside a fetch
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (slot_q == $past(wr_data)));

  // R4: without post or fetch the slot does not move
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !fetch_req) |=> $stable(slot_q));

  // R6: command byte is the top byte of the fetched word
  assert_cmd_field_R6: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_q |-> (fetch_cmd_q == fetch_data_q[DATA_W-1 -: CMD_W]));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int unsigned N_CPU = 4,
  localparam int unsigned TGT_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int unsigned DATA_W = ipi_mbox_pkg::MSG_W,
  localparam int unsigned CMD_W  = ipi_mbox_pkg::CMD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CPU-1:0]        post_valid,
  input  logic [N_CPU*TGT_W-1:0]  post_target,
  input  logic [N_CPU*DATA_W-1:0] post_data,
  input  logic [N_CPU-1:0]        fetch_req,
  output logic [N_CPU-1:0]        fetch_valid,
  output logic [N_CPU*DATA_W-1:0] fetch_data,
  output logic [N_CPU*CMD_W-1:0]  fetch_cmd,
  output logic [N_CPU*DATA_W-1:0] peek_data,
  output logic [N_CPU-1:0]        ipi_pending
);
  genvar t;
  generate
    for (t = 0; t < N_CPU; t++) begin : g_cpu
      logic [N_CPU-1:0]  grant;
      logic              we;
      logic [DATA_W-1:0] wdata;

      ipi_post_arbiter #(
        .N_CPU (N_CPU),
        .TGT_W (TGT_W),
        .DATA_W(DATA_W),
        .TARGET(t)
      ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .post_valid (post_valid),
        .post_target(post_target),
        .post_data  (post_data),
        .grant      (grant),
        .win_we     (we),
        .win_data   (wdata)
      );

      ipi_slot #(
        .DATA_W(DATA_W),
        .CMD_W (CMD_W)
      ) u_slot (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (we),
        .wr_data      (wdata),
        .fetch_req    (fetch_req[t]),
        .slot_q       (peek_data[t*DATA_W +: DATA_W]),
        .pending_q    (ipi_pending[t]),
        .fetch_valid_q(fetch_valid[t]),
        .fetch_data_q (fetch_data[t*DATA_W +: DATA_W]),
        .fetch_cmd_q  (fetch_cmd[t*CMD_W +: CMD_W])
      );

      // R1: everything is empty in the first cycle after reset
      assert_reset_empty_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!ipi_pending[t] && !fetch_valid[t]
                        && peek_data[t*DATA_W +: DATA_W] == '0));
    end
  endgenerate
endmodule

// File: tb/ipi_mailbox_test.sv
module ipi_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int TW = 2;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]    pv;
  logic [TW-1:0]   pt [N];
  logic [DW-1:0]   pd [N];
  logic [N-1:0]    fr;

  logic [N*TW-1:0] post_target;
  logic [N*DW-1:0] post_data;
  logic [N-1:0]    fetch_valid, ipi_pending;
  logic [N*DW-1:0] fetch_data, peek_data;
  logic [N*8-1:0]  fetch_cmd;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      post_target[i*TW +: TW] = pt[i];
      post_data[i*DW +: DW]   = pd[i];
    end
  end

  ipi_mailbox #(.N_CPU(N)) uut (
    .clk(clk), .rst(rst),
    .post_valid(pv), .post_target(post_target), .post_data(post_data),
    .fetch_req(fr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_cmd(fetch_cmd), .peek_data(peek_data), .ipi_pending(ipi_pending)
  );

  // reference model
  logic [DW-1:0] m_slot [N];
  logic [DW-1:0] m_fdata [N];
  logic          m_fvalid [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input string what, input int cpu,
                     input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s cpu%0d got %h expected %h", tag, what, cpu, got, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    for (int t = 0; t < N; t++) begin
      chk({"R4/", ctx}, "peek_data", t, peek_data[t*DW +: DW], m_slot[t]);
      chk({"R5/", ctx}, "ipi_pending", t, 64'(ipi_pending[t]), 64'(m_slot[t] != 0));
      chk({"R3/", ctx}, "fetch_valid", t, 64'(fetch_valid[t]), 64'(m_fvalid[t]));
      chk({"R3/", ctx}, "fetch_data", t, fetch_data[t*DW +: DW], m_fdata[t]);
      chk({"R6/", ctx}, "fetch_cmd", t, 64'(fetch_cmd[t*8 +: 8]), 64'(m_fdata[t][63:56]));
    end
  endtask

  task automatic clear_inputs();
    pv = '0; fr = '0;
    for (int i = 0; i < N; i++) begin pt[i] = '0; pd[i] = '0; end
  endtask

  // Inputs are already driven (at a negedge); take one edge, advance the model, check.
  task automatic step(input string ctx);
    int win;
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      win = -1;
      for (int s = 0; s < N; s++)
        if (win < 0 && pv[s] && int'(pt[s]) == t && pd[s] != 0) win = s;
      m_fvalid[t] = fr[t];
      if (fr[t]) m_fdata[t] = m_slot[t];
      if (win >= 0)   m_slot[t] = pd[win];
      else if (fr[t]) m_slot[t] = '0;
    end
    @(negedge clk);
    check_all(ctx);
    clear_inputs();
  endtask

  task automatic post1(input int s, input int t, input logic [DW-1:0] d);
    pv[s] = 1'b1; pt[s] = TW'(t); pd[s] = d;
  endtask

  initial begin
    clear_inputs();
    for (int t = 0; t < N; t++) begin
      m_slot[t] = '0; m_fdata[t] = '0; m_fvalid[t] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset state");

    // R2: post then overwrite before any read
    post1(0, 2, 64'hA1_00000000001234); step("R2 first post");
    post1(3, 2, 64'hB2_0000000000BEEF); step("R2 overwrite");
    chk("R2", "overwritten slot", 2, peek_data[2*DW +: DW], 64'hB2_0000000000BEEF);
    // R3: fetch returns latest and empties
    fr[2] = 1'b1; step("R3 fetch");
    chk("R3", "fetched word", 2, fetch_data[2*DW +: DW], 64'hB2_0000000000BEEF);
    chk("R3", "slot after fetch", 2, peek_data[2*DW +: DW], 64'h0);
    // R3: fetch of an empty slot gives zero
    fr[2] = 1'b1; step("R3 empty fetch");
    // R8: zero post ignored
    post1(1, 1, 64'h5); step("R8 setup");
    post1(0, 1, 64'h0); step("R8 zero post");
    chk("R8", "slot unchanged by zero post", 1, peek_data[1*DW +: DW], 64'h5);
    // R7: all sources to one target, lowest wins
    for (int s = 0; s < N; s++) post1(s, 3, 64'h1000 + s);
    step("R7 four posters");
    chk("R7", "lowest source wins", 3, peek_data[3*DW +: DW], 64'h1000);
    // R7 + R8: zero word from source 0 does not win
    post1(0, 3, 64'h0); post1(2, 3, 64'h2222); post1(1, 3, 64'h1111);
    step("R7 R8 zero lowest");
    chk("R8", "zero poster skipped", 3, peek_data[3*DW +: DW], 64'h1111);
    // R9: post and fetch together
    post1(2, 3, 64'h7F_00000000000009); fr[3] = 1'b1; step("R9 collide");
    chk("R9", "fetch returns old", 3, fetch_data[3*DW +: DW], 64'h1111);
    chk("R9", "slot keeps new", 3, peek_data[3*DW +: DW], 64'h7F_00000000000009);
    chk("R6", "command byte", 3, 64'(fetch_cmd[3*8 +: 8]), 64'h0);
    fr[3] = 1'b1; step("R6 cmd fetch");
    chk("R6", "command byte", 3, 64'(fetch_cmd[3*8 +: 8]), 64'h7F);

    // exhaustive source/target/fetch-pattern sweep (R2 R3 R4 R5)
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++)
        for (int f = 0; f < 16; f++) begin
          post1(s, t, {8'(s*16 + t + 1), 40'h0, 8'(f), 8'(s ^ t)});
          step("R2 sweep post");
          fr = 4'(f);
          step("R3 sweep fetch");
        end

    // pseudo-random mix (R7 R8 R9)
    for (int k = 0; k < 2000; k++) begin
      for (int s = 0; s < N; s++) begin
        pv[s] = 1'($urandom_range(0, 1));
        pt[s] = TW'($urandom_range(0, N - 1));
        pd[s] = ($urandom_range(0, 3) == 0) ? 64'h0 : {$urandom(), $urandom()};
      end
      fr = 4'($urandom_range(0, 15));
      step("R7 R9 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule